// File: doc/BRIEF.md
# Multicycle Path Hold Monitor

This block is a runtime checker. It sits beside a source register, a destination register and the combinational path that joins them, where that path has been given a relaxed timing budget of several clock cycles. It watches the source register's value, a bit that says whether the path is currently sensitized, and the destination's capture enable. Whenever the destination captures through a sensitized path while the source value has not been held long enough, the checker reports a violation.

Stability is counted backward from the capture edge, one cycle per sampled clock. A source that sits quiet for a long time and then changes shortly before a capture is caught. A source that changes freely while the path is masked is not reported. When the path also crosses an asynchronous clock boundary, a parameter adds one extra cycle to the hold window. Each violation produces a single-cycle pulse. A flag then stays set until reset, and a saturating counter keeps the running total.

Top module: `mcp_hold_monitor`

## Requirements
- R1: Let the hold length be HOLD = CYCLES, or CYCLES+1 when ASYNC_XING is nonzero. The run length counts how many consecutive sampled cycles back from the current one the source has shown the same value: 0 when it differs from the previous cycle's value. When `dst_capture` and `path_sens` are both 1 and the run length is below HOLD, `err_pulse` is 1 in that same cycle.
- R2: A sensitized capture whose run length is HOLD or more gives `err_pulse` = 0.
- R3: A source that stayed unchanged for more than HOLD cycles and then changes is judged only on the run length after its latest change. A sensitized capture fewer than HOLD cycles after that change is a violation.
- R4: A capture with `path_sens` = 0 never gives a pulse and leaves `err_sticky` and `viol_count` untouched, however recently the source changed.
- R5: A change in any single bit of `src_data`, including the most significant bit, restarts the run length at 0.
- R6: `err_sticky` becomes 1 on the clock edge that ends a cycle with `err_pulse` = 1. It then stays 1 until reset.
- R7: `viol_count` rises by one on each clock edge that ends a cycle with `err_pulse` = 1. It saturates at 2^CNT_W-1.
- R8: While `rst` is 1, `err_pulse` is 0, and `err_sticky` and `viol_count` are cleared to 0. The source value present during reset is the baseline: a sensitized capture in the first cycle after reset, with the source unchanged, is not a violation.
- R9: With ASYNC_XING nonzero, a sensitized capture at run length CYCLES is a violation, and one at run length CYCLES+1 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by source and destination registers |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | DATA_W (8) | Current value of the source register |
| path_sens | input | 1 | 1 when the path from source to destination is sensitized |
| dst_capture | input | 1 | 1 in a cycle where the destination register loads |
| err_pulse | output | 1 | Violation in the current cycle |
| err_sticky | output | 1 | At least one violation since reset |
| viol_count | output | CNT_W (16) | Saturating count of violations since reset |

## Verification
The bench targets the window boundary: a capture at run length HOLD-1 must be flagged and one at HOLD must not. A monitor off by one would flag the second capture or miss the first. It also covers a late change after a long quiet period, which a monitor that checks only overall stability would miss. A flip of only the top bit is covered as well; a narrowed comparison would not see it. Masked captures are exercised to make sure a design that ignores `path_sens` shows up through a raised flag or count. On a second instance, the extra cycle for asynchronous crossings and counter saturation are checked, along with the baseline loaded during reset: a monitor that starts with a cleared run length would report a false violation right after reset.

// File: rtl/mcp_hold_pkg.sv
package mcp_hold_pkg;

  // Run length of an unchanged source, saturating at the hold length.
  function automatic int unsigned run_next(logic changed, int unsigned run_prev,
                                           int unsigned hold);
    if (changed) return 0;
    if (run_prev >= hold) return hold;
    return run_prev + 1;
  endfunction

  // Capture through a sensitized path with too short a hold.
  function automatic logic hold_broken(logic capture, logic sens,
                                       int unsigned run_len, int unsigned hold);
    return capture && sens && (run_len < hold);
  endfunction

  // Saturating increment of a violation total.
  function automatic int unsigned tally_next(int unsigned cur, int unsigned max_val);
    return (cur >= max_val) ? max_val : cur + 1;
  endfunction

endpackage

// File: rtl/mcp_change_detect.sv
module mcp_change_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_changed
);
  logic [DATA_W-1:0] prev_q;

  // Loaded every cycle, reset included, so the reset value becomes the baseline.
  always_ff @(posedge clk) begin
    prev_q <= src_data;
  end

  assign src_changed = |(src_data ^ prev_q);
endmodule

// File: rtl/mcp_age_track.sv
module mcp_age_track
  import mcp_hold_pkg::*;
#(
  parameter int HOLD  = 3,
  parameter int AGE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_changed,
  output logic [AGE_W-1:0] age_now
);
  localparam int unsigned HOLD_U = HOLD;
  logic [AGE_W-1:0] age_q;

  always_comb begin
    age_now = AGE_W'(run_next(src_changed, int'(age_q), HOLD_U));
  end

  always_ff @(posedge clk) begin
    if (rst) age_q <= AGE_W'(HOLD_U);
    else     age_q <= age_now;
  end
endmodule

// File: rtl/mcp_viol_log.sv
module mcp_viol_log
  import mcp_hold_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             viol_now,
  output logic             err_sticky,
  output logic [CNT_W-1:0] viol_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_sticky <= 1'b0;
      viol_count <= '0;
    end else if (viol_now) begin
      err_sticky <= 1'b1;
      if (viol_count != CNT_MAX) viol_count <= viol_count + 1'b1;
    end
  end
endmodule

// File: rtl/mcp_hold_monitor.sv
module mcp_hold_monitor
  import mcp_hold_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CYCLES     = 3,
  parameter int ASYNC_XING = 0,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_data,
  input  logic              path_sens,
  input  logic              dst_capture,
  output logic              err_pulse,
  output logic              err_sticky,
  output logic [CNT_W-1:0]  viol_count
);
  localparam int HOLD  = CYCLES + ((ASYNC_XING != 0) ? 1 : 0);
  localparam int AGE_W = $clog2(HOLD + 1);
  localparam int unsigned HOLD_U = HOLD;

  logic             src_changed;
  logic [AGE_W-1:0] age_now;
  logic             viol_now;

  mcp_change_detect #(.DATA_W(DATA_W)) u_chg (
    .clk        (clk),
    .src_data   (src_data),
    .src_changed(src_changed)
  );

  mcp_age_track #(.HOLD(HOLD), .AGE_W(AGE_W)) u_age (
    .clk        (clk),
    .rst        (rst),
    .src_changed(src_changed),
    .age_now    (age_now)
  );

  always_comb begin
    viol_now = !rst && hold_broken(dst_capture, path_sens, int'(age_now), HOLD_U);
  end

  mcp_viol_log #(.CNT_W(CNT_W)) u_log (
    .clk       (clk),
    .rst       (rst),
    .viol_now  (viol_now),
    .err_sticky(err_sticky),
    .viol_count(viol_count)
  );

  assign err_pulse = viol_now;
endmodule

// File: rtl/mcp_hold_monitor_chk.sv
module mcp_hold_monitor_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] src_data,
  input logic              path_sens,
  input logic              dst_capture,
  input logic              err_pulse,
  input logic              err_sticky,
  input logic [CNT_W-1:0]  viol_count,
  input logic              src_changed
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1 / R5: a sensitized capture in the cycle of a source change is flagged
  a_r1_change_flagged: assert property (@(posedge clk) disable iff (rst)
    (dst_capture && path_sens && (src_data != $past(src_data))) |-> err_pulse);

  // R4: a masked path never reports
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    !path_sens |-> !err_pulse);

  // R1: a pulse needs a capture
  a_r1_pulse_needs_capture: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (dst_capture && path_sens));

  // R5: the change detector sees any bit difference
  a_r5_change_seen: assert property (@(posedge clk) disable iff (rst)
    (src_data != $past(src_data)) |-> src_changed);

  // R6: sticky sets after a pulse and then holds
  a_r6_sticky_sets: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> err_sticky);
  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

  // R7: count steps once per pulse, saturating, and is otherwise stable
  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> viol_count == (($past(viol_count) == CNT_MAX) ? CNT_MAX
                                  : $past(viol_count) + 1'b1));
  a_r7_count_stable: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |=> $stable(viol_count));

  // R8: no pulse while reset is held
  always_comb begin
    if (rst) a_r8_no_pulse_in_reset: assert (!err_pulse);
  end
endmodule

bind mcp_hold_monitor mcp_hold_monitor_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_data   (src_data),
  .path_sens  (path_sens),
  .dst_capture(dst_capture),
  .err_pulse  (err_pulse),
  .err_sticky (err_sticky),
  .viol_count (viol_count),
  .src_changed(src_changed)
);

// File: tb/tb_mcp_hold_monitor.sv
module tb_mcp_hold_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src = 8'h00;
  logic       sens = 1'b0;
  logic       cap = 1'b0;

  logic        pulse_a, sticky_a;
  logic [15:0] count_a;
  logic        pulse_x, sticky_x;
  logic [2:0]  count_x;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Hold length 3, synchronous path, 16-bit count.
  mcp_hold_monitor #(.DATA_W(8), .CYCLES(3), .ASYNC_XING(0), .CNT_W(16)) dut (
    .clk(clk), .rst(rst), .src_data(src), .path_sens(sens), .dst_capture(cap),
    .err_pulse(pulse_a), .err_sticky(sticky_a), .viol_count(count_a));

  // Hold length 4 (asynchronous crossing), 3-bit count.
  mcp_hold_monitor #(.DATA_W(8), .CYCLES(3), .ASYNC_XING(1), .CNT_W(3)) dut_x (
    .clk(clk), .rst(rst), .src_data(src), .path_sens(sens), .dst_capture(cap),
    .err_pulse(pulse_x), .err_sticky(sticky_x), .viol_count(count_x));

  // {src[7:0], sens, cap, expected pulse} for the hold-3 instance.
  localparam logic [10:0] VEC [NVEC] = '{
    {8'h00, 1'b1, 1'b1, 1'b0},   // R8 baseline, no violation
    {8'h5A, 1'b1, 1'b1, 1'b1},   // R1 run 0
    {8'h5A, 1'b1, 1'b1, 1'b1},   // R1 run 1
    {8'h5A, 1'b1, 1'b1, 1'b1},   // R1 run 2
    {8'h5A, 1'b1, 1'b1, 1'b0},   // R2 run 3
    {8'h5A, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b1, 1'b0, 1'b0},
    {8'h5B, 1'b0, 1'b1, 1'b0},   // R4 masked capture on a change
    {8'h5B, 1'b1, 1'b0, 1'b0},
    {8'h5B, 1'b1, 1'b1, 1'b1},   // R3 late change after long quiet
    {8'h5B, 1'b1, 1'b1, 1'b0},   // R2
    {8'hDB, 1'b1, 1'b1, 1'b1},   // R5 top bit only
    {8'hDB, 1'b0, 1'b1, 1'b0},   // R4
    {8'hDB, 1'b0, 1'b1, 1'b0},   // R4
    {8'hDB, 1'b1, 1'b1, 1'b0},   // R2 run 3
    {8'hDB, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic step(input logic [7:0] s_val, input logic sn, input logic cp);
    @(negedge clk);
    src = s_val; sens = sn; cap = cp;
    #(CLK_PERIOD/4);
  endtask

  task automatic do_reset(input logic [7:0] base);
    @(negedge clk);
    rst = 1'b1; src = base; sens = 1'b0; cap = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    int exp_count;
    exp_count = 0;

    // R8: reset state, and no pulse during reset despite changing source
    repeat (2) @(negedge clk);
    src = 8'h11; sens = 1'b1; cap = 1'b1;
    #(CLK_PERIOD/4);
    check(pulse_a == 1'b0, "R8 pulse in reset", pulse_a, 0);
    @(negedge clk);
    src = 8'h22;
    #(CLK_PERIOD/4);
    check(pulse_x == 1'b0, "R8 pulse in reset x", pulse_x, 0);
    check(sticky_a == 1'b0 && count_a == 16'd0, "R8 outputs in reset", count_a, 0);
    do_reset(8'h00);
    check(sticky_a == 1'b0, "R8 sticky after reset", sticky_a, 0);
    check(count_a == 16'd0, "R8 count after reset", count_a, 0);

    // Vector table on the hold-3 instance
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][10:3], VEC[i][2], VEC[i][1]);
      check(pulse_a == VEC[i][0], $sformatf("R1/R2/R3/R4/R5 vector %0d", i),
            pulse_a, VEC[i][0]);
      if (VEC[i][0]) exp_count++;
    end
    step(8'hDB, 1'b0, 1'b0);
    check(count_a == 16'(exp_count), "R7 count after table", count_a, exp_count);
    check(sticky_a == 1'b1, "R6 sticky after table", sticky_a, 1);

    // R6: sticky holds over quiet cycles
    for (int i = 0; i < 6; i++) step(8'hDB, 1'b1, 1'b1);
    check(sticky_a == 1'b1, "R6 sticky holds", sticky_a, 1);
    check(count_a == 16'(exp_count), "R7 count stable without violations", count_a, exp_count);
    do_reset(8'h00);
    check(sticky_a == 1'b0, "R6 sticky cleared by reset", sticky_a, 0);

    // R4: masked captures with a busy source leave everything untouched
    for (int i = 0; i < 8; i++) step(8'(i * 37 + 1), 1'b0, 1'b1);
    step(8'h40, 1'b0, 1'b0);
    check(pulse_a == 1'b0, "R4 no pulse masked", pulse_a, 0);
    check(sticky_a == 1'b0, "R4 sticky untouched", sticky_a, 0);
    check(count_a == 16'd0, "R4 count untouched", count_a, 0);

    // R9: hold 3 versus hold 4 at the window boundary
    do_reset(8'h00);
    step(8'h11, 1'b1, 1'b0);
    step(8'h11, 1'b1, 1'b0);
    step(8'h11, 1'b1, 1'b0);
    step(8'h11, 1'b1, 1'b1);
    check(pulse_a == 1'b0, "R2 run 3 sync", pulse_a, 0);
    check(pulse_x == 1'b1, "R9 run 3 async", pulse_x, 1);
    step(8'h11, 1'b1, 1'b1);
    check(pulse_x == 1'b0, "R9 run 4 async", pulse_x, 0);

    // R8: baseline after reset on the async instance too
    do_reset(8'h77);
    step(8'h77, 1'b1, 1'b1);
    check(pulse_x == 1'b0, "R8 baseline async", pulse_x, 0);
    check(pulse_a == 1'b0, "R8 baseline sync", pulse_a, 0);

    // R7: saturation of the 3-bit count
    for (int i = 0; i < 10; i++) begin
      step(8'(i + 1), 1'b1, 1'b1);
      check(pulse_x == 1'b1, "R1 back-to-back changes", pulse_x, 1);
    end
    step(8'h0A, 1'b0, 1'b0);
    check(count_x == 3'd7, "R7 count saturates", count_x, 7);
    check(count_a == 16'd10, "R7 count ten", count_a, 10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule